// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry

This block conditions the second operand of an ALU before the arithmetic or logic stage consumes it. A single combinational pass shifts or rotates a data word by an amount taken from either an immediate field or a register. In the same pass it produces the bit that a logical instruction would later place in the carry flag. Because the result feeds the ALU input directly, an instruction such as "add a register to itself shifted left by one" completes without a separate shift step.

Five operation kinds are supported: logical left, logical right, arithmetic right, rotate right, and a one-bit rotate right through the incoming carry. The carry output is the last bit pushed off the end of the word. When nothing is shifted, the carry output is the incoming flag. The amount is wide enough to express values beyond the word width, and those values have defined results for every kind.

Top module: `operand_shifter`

## Requirements
- R1: With kind_i=0 (logical left) and an amount n in 1..WIDTH-1, result_o is operand_i shifted left by n with zeros filled in, and carry_o is operand_i[WIDTH-n].
- R2: With kind_i=1 (logical right) and n in 1..WIDTH-1, result_o is operand_i shifted right by n with zeros filled in, and carry_o is operand_i[n-1].
- R3: With kind_i=2 (arithmetic right) and n in 1..WIDTH-1, result_o is operand_i shifted right by n with copies of operand_i[WIDTH-1] filled in, and carry_o is operand_i[n-1].
- R4: With kind_i=3 (rotate right), result_o is operand_i rotated right by n modulo WIDTH, and for nonzero n carry_o is operand_i[(n-1) mod WIDTH]. A nonzero multiple of WIDTH therefore leaves the word unchanged and gives carry_o = operand_i[WIDTH-1].
- R5: With kind_i=4 (extended rotate), result_o is {carry_i, operand_i[WIDTH-1:1]} and carry_o is operand_i[0], whatever the amount.
- R6: For kind_i in 0..3 with an amount of zero, result_o equals operand_i and carry_o equals carry_i.
- R7: A logical shift by exactly WIDTH gives result_o = 0. carry_o is operand_i[0] for a left shift and operand_i[WIDTH-1] for a right shift.
- R8: A logical shift (kind_i 0 or 1) by more than WIDTH gives result_o = 0 and carry_o = 0.
- R9: An arithmetic right shift by WIDTH or more fills every bit of result_o with operand_i[WIDTH-1], and carry_o equals that bit.
- R10: amt_src_i=0 takes the amount from amt_imm_i and amt_src_i=1 takes it from amt_reg_i. The unselected amount input has no effect on either output.
- R11: kind_i codes 5, 6 and 7 pass operand_i to result_o unchanged and pass carry_i to carry_o.
- R12: An operand of 0x00000005 shifted left by 1 gives 0x0000000A, so adding it to the unshifted operand gives 0x0000000F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | WIDTH | Word to be shifted |
| kind_i | input | 3 | Operation kind: 0 left, 1 right, 2 arithmetic right, 3 rotate, 4 extended rotate |
| amt_src_i | input | 1 | Amount source: 0 immediate, 1 register |
| amt_imm_i | input | AMT_W | Amount from the instruction immediate |
| amt_reg_i | input | AMT_W | Amount from a register |
| carry_i | input | 1 | Current carry flag |
| result_o | output | WIDTH | Shifted operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The bench builds the block with the default WIDTH of 32, which makes AMT_W 6. Amounts from 0 to 63 can therefore be applied. This covers every in-range shift, the exact word-width case, and the amounts above the word width that R8 and R9 define and that wrap under rotation in R4. At this width a per-bit reference that applies one single-step shift per amount unit can be swept over every amount for each kind.

// File: rtl/bsh_pkg.sv
package bsh_pkg;
  typedef enum logic [2:0] {
    K_LSL = 3'd0,
    K_LSR = 3'd1,
    K_ASR = 3'd2,
    K_ROR = 3'd3,
    K_RRX = 3'd4
  } shift_kind_e;
endpackage

// File: rtl/bsh_amt_mux.sv
module bsh_amt_mux #(
  parameter int unsigned AMT_W = 6
) (
  input  logic             src_i,
  input  logic [AMT_W-1:0] imm_i,
  input  logic [AMT_W-1:0] reg_i,
  output logic [AMT_W-1:0] amt_o
);
  assign amt_o = src_i ? reg_i : imm_i;
endmodule

// File: rtl/bsh_rshift_net.sv
// Logarithmic right shifter; rotate_i wraps low bits, else fill_i is shifted in.
module bsh_rshift_net #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned LOG_W = 5
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [LOG_W-1:0] amt_i,
  input  logic             fill_i,
  input  logic             rotate_i,
  output logic [WIDTH-1:0] data_o
);
  logic [WIDTH-1:0] stage [0:LOG_W];

  assign stage[0] = data_i;

  for (genvar s = 0; s < LOG_W; s++) begin : g_stage
    localparam int unsigned STEP = 1 << s;
    logic [STEP-1:0] wrap;
    assign wrap         = rotate_i ? stage[s][STEP-1:0] : {STEP{fill_i}};
    assign stage[s+1]   = amt_i[s] ? {wrap, stage[s][WIDTH-1:STEP]} : stage[s];
  end

  assign data_o = stage[LOG_W];
endmodule

// File: rtl/bsh_carry_pick.sv
module bsh_carry_pick #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned LOG_W = 5
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [LOG_W-1:0] idx_i,
  output logic             bit_o
);
  assign bit_o = data_i[idx_i];
endmodule

// File: rtl/operand_shifter.sv
module operand_shifter
  import bsh_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned LOG_W = $clog2(WIDTH),
  parameter int unsigned AMT_W = LOG_W + 1
) (
  input  logic [WIDTH-1:0] operand_i,
  input  logic [2:0]       kind_i,
  input  logic             amt_src_i,
  input  logic [AMT_W-1:0] amt_imm_i,
  input  logic [AMT_W-1:0] amt_reg_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o
);
  localparam logic [AMT_W-1:0] W_AMT = AMT_W'(WIDTH);

  shift_kind_e      kind;
  logic [AMT_W-1:0] amt;
  logic [LOG_W-1:0] amt_lo;
  logic [LOG_W-1:0] pick_idx;
  logic [WIDTH-1:0] op_rev;
  logic [WIDTH-1:0] net_in;
  logic [WIDTH-1:0] net_out;
  logic [WIDTH-1:0] net_fix;
  logic             is_left;
  logic             is_rot;
  logic             fill;
  logic             pick_bit;
  logic             amt_zero;
  logic             amt_full;
  logic             amt_over;
  logic             known;

  assign kind = shift_kind_e'(kind_i);

  bsh_amt_mux #(.AMT_W(AMT_W)) u_amt (
    .src_i (amt_src_i),
    .imm_i (amt_imm_i),
    .reg_i (amt_reg_i),
    .amt_o (amt)
  );

  assign amt_lo   = amt[LOG_W-1:0];
  assign amt_zero = (amt == '0);
  assign amt_full = (amt >= W_AMT);
  assign amt_over = (amt > W_AMT);
  assign pick_idx = amt_lo - LOG_W'(1);

  assign is_left = (kind == K_LSL);
  assign is_rot  = (kind == K_ROR);
  assign fill    = (kind == K_ASR) & operand_i[WIDTH-1];
  assign known   = (kind_i <= 3'd3);

  // Left shifts reuse the right network on the bit-reversed word.
  assign op_rev = {<<{operand_i}};
  assign net_in = is_left ? op_rev : operand_i;

  bsh_rshift_net #(.WIDTH(WIDTH), .LOG_W(LOG_W)) u_net (
    .data_i   (net_in),
    .amt_i    (amt_lo),
    .fill_i   (fill),
    .rotate_i (is_rot),
    .data_o   (net_out)
  );

  bsh_carry_pick #(.WIDTH(WIDTH), .LOG_W(LOG_W)) u_pick (
    .data_i (net_in),
    .idx_i  (pick_idx),
    .bit_o  (pick_bit)
  );

  assign net_fix = is_left ? {<<{net_out}} : net_out;

  always_comb begin
    result_o = operand_i;
    carry_o  = carry_i;
    if (kind == K_RRX) begin
      result_o = {carry_i, operand_i[WIDTH-1:1]};
      carry_o  = operand_i[0];
    end else if (known && !amt_zero) begin
      if (is_rot || !amt_full) begin
        result_o = net_fix;
        carry_o  = pick_bit;
      end else begin
        result_o = {WIDTH{fill}};
        carry_o  = amt_over ? fill : pick_bit;
      end
    end
  end
endmodule

// File: rtl/operand_shifter_chk.sv
module operand_shifter_chk #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned LOG_W = $clog2(WIDTH),
  parameter int unsigned AMT_W = LOG_W + 1
) (
  input logic [WIDTH-1:0] operand_i,
  input logic [2:0]       kind_i,
  input logic             amt_src_i,
  input logic [AMT_W-1:0] amt_imm_i,
  input logic [AMT_W-1:0] amt_reg_i,
  input logic             carry_i,
  input logic [WIDTH-1:0] result_o,
  input logic             carry_o
);
  logic [AMT_W-1:0] eff;
  assign eff = amt_src_i ? amt_reg_i : amt_imm_i;

  always_comb begin
    if (kind_i <= 3'd3 && eff == '0)
      p_zero_pass_r6: assert (result_o == operand_i && carry_o == carry_i);
    if (kind_i == 3'd4)
      p_rrx_carry_r5: assert (result_o[WIDTH-1] == carry_i && carry_o == operand_i[0]
                              && result_o[WIDTH-2:0] == operand_i[WIDTH-1:1]);
    if (kind_i == 3'd3)
      p_rot_keeps_ones_r4: assert ($countones(result_o) == $countones(operand_i));
    if (kind_i == 3'd2)
      p_asr_sign_r3: assert (result_o[WIDTH-1] == operand_i[WIDTH-1]);
    if (kind_i == 3'd0 && eff == AMT_W'(WIDTH))
      p_lsl_full_r7: assert (result_o == '0 && carry_o == operand_i[0]);
    if (kind_i <= 3'd1 && eff > AMT_W'(WIDTH))
      p_logic_over_r8: assert (result_o == '0 && !carry_o);
    if (kind_i >= 3'd5)
      p_reserved_pass_r11: assert (result_o == operand_i && carry_o == carry_i);
  end
endmodule

bind operand_shifter operand_shifter_chk #(.WIDTH(WIDTH), .LOG_W(LOG_W), .AMT_W(AMT_W)) u_chk (
  .operand_i (operand_i),
  .kind_i    (kind_i),
  .amt_src_i (amt_src_i),
  .amt_imm_i (amt_imm_i),
  .amt_reg_i (amt_reg_i),
  .carry_i   (carry_i),
  .result_o  (result_o),
  .carry_o   (carry_o)
);

// File: tb/operand_shifter_bench.sv
module operand_shifter_bench;
  localparam int W = 32;
  localparam int A = 6;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] operand_i = '0;
  logic [2:0]   kind_i = '0;
  logic         amt_src_i = 1'b0;
  logic [A-1:0] amt_imm_i = '0;
  logic [A-1:0] amt_reg_i = '0;
  logic         carry_i = 1'b0;
  logic [W-1:0] result_o;
  logic         carry_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  operand_shifter u_operand_shifter (
    .operand_i (operand_i),
    .kind_i    (kind_i),
    .amt_src_i (amt_src_i),
    .amt_imm_i (amt_imm_i),
    .amt_reg_i (amt_reg_i),
    .carry_i   (carry_i),
    .result_o  (result_o),
    .carry_o   (carry_o)
  );

  // Reference: one single-bit step per amount unit.
  task automatic model(input logic [W-1:0] op, input logic [2:0] k, input int n,
                       input logic cin, output logic [W-1:0] r, output logic c);
    r = op;
    c = cin;
    case (k)
      3'd0: for (int i = 0; i < n; i++) begin c = r[W-1]; r = r << 1; end
      3'd1: for (int i = 0; i < n; i++) begin c = r[0]; r = r >> 1; end
      3'd2: for (int i = 0; i < n; i++) begin c = r[0]; r = {r[W-1], r[W-1:1]}; end
      3'd3: for (int i = 0; i < n; i++) begin c = r[0]; r = {r[0], r[W-1:1]}; end
      3'd4: begin r = {cin, op[W-1:1]}; c = op[0]; end
      default: ;
    endcase
  endtask

  task automatic check(input string req, input logic [W-1:0] er, input logic ec);
    checks++;
    if (result_o !== er || carry_o !== ec) begin
      errors++;
      $display("FAIL %s: actual result=%h carry=%b expected result=%h carry=%b",
               req, result_o, carry_o, er, ec);
    end
  endtask

  task automatic apply(input logic [W-1:0] op, input logic [2:0] k, input logic src,
                       input logic [A-1:0] imm, input logic [A-1:0] rg, input logic cin);
    @(negedge clk);
    operand_i = op; kind_i = k; amt_src_i = src;
    amt_imm_i = imm; amt_reg_i = rg; carry_i = cin;
    #1;
  endtask

  task automatic run(input string req, input logic [W-1:0] op, input logic [2:0] k,
                     input int n, input logic cin);
    logic [W-1:0] er;
    logic ec;
    apply(op, k, 1'b0, A'(n), ~A'(n), cin);
    model(op, k, n, cin, er, ec);
    check(req, er, ec);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R6 reset", '0, 1'b0);
  endtask

  task automatic t_lsl_r1;
    for (int n = 1; n < W; n++) begin
      run("R1", 32'h8000_0001, 3'd0, n, 1'b0);
      run("R1", 32'hA5C3_0F96, 3'd0, n, 1'b1);
    end
  endtask

  task automatic t_lsr_r2;
    for (int n = 1; n < W; n++) begin
      run("R2", 32'hF000_000F, 3'd1, n, 1'b1);
      run("R2", 32'h3C69_5AA5, 3'd1, n, 1'b0);
    end
  endtask

  task automatic t_asr_r3;
    for (int n = 1; n < W; n++) begin
      run("R3", 32'h8765_4321, 3'd2, n, 1'b0);
      run("R3", 32'h4765_4321, 3'd2, n, 1'b1);
    end
  endtask

  task automatic t_ror_r4;
    for (int n = 1; n < 64; n++) run("R4", 32'h8123_4567, 3'd3, n, 1'b0);
    run("R4 multiple", 32'h8000_0002, 3'd3, 32, 1'b0);
    apply(32'h0000_0001, 3'd3, 1'b0, 6'd32, 6'd0, 1'b0);
    check("R4 explicit", 32'h0000_0001, 1'b0);
  endtask

  task automatic t_rrx_r5;
    for (int n = 0; n < 64; n += 13) begin
      run("R5", 32'h0000_0003, 3'd4, n, 1'b1);
      run("R5", 32'hFFFF_FFFE, 3'd4, n, 1'b0);
    end
    apply(32'h0000_0001, 3'd4, 1'b0, 6'd7, 6'd0, 1'b1);
    check("R5 explicit", 32'h8000_0000, 1'b1);
  endtask

  task automatic t_zero_r6;
    for (int k = 0; k < 4; k++) begin
      run("R6", 32'hDEAD_BEEF, 3'(k), 0, 1'b1);
      run("R6", 32'h1234_5678, 3'(k), 0, 1'b0);
    end
  endtask

  task automatic t_full_r7;
    apply(32'h7FFF_FFFF, 3'd0, 1'b0, 6'd32, 6'd0, 1'b0);
    check("R7 left", 32'h0, 1'b1);
    apply(32'h7FFF_FFFF, 3'd1, 1'b0, 6'd32, 6'd0, 1'b1);
    check("R7 right", 32'h0, 1'b0);
    apply(32'h8000_0000, 3'd1, 1'b0, 6'd32, 6'd0, 1'b0);
    check("R7 right msb", 32'h0, 1'b1);
  endtask

  task automatic t_over_r8;
    for (int n = 33; n < 64; n++) begin
      run("R8", 32'hFFFF_FFFF, 3'd0, n, 1'b1);
      run("R8", 32'hFFFF_FFFF, 3'd1, n, 1'b1);
    end
  endtask

  task automatic t_asr_big_r9;
    for (int n = 32; n < 64; n += 3) begin
      run("R9", 32'h8000_0000, 3'd2, n, 1'b0);
      run("R9", 32'h7FFF_FFFF, 3'd2, n, 1'b1);
    end
    apply(32'h8000_0000, 3'd2, 1'b1, 6'd0, 6'd40, 1'b0);
    check("R9 explicit", 32'hFFFF_FFFF, 1'b1);
  endtask

  task automatic t_src_r10;
    apply(32'h0000_00F0, 3'd1, 1'b0, 6'd4, 6'd9, 1'b0);
    check("R10 imm", 32'h0000_000F, 1'b0);
    apply(32'h0000_00F0, 3'd1, 1'b0, 6'd4, 6'd1, 1'b0);
    check("R10 reg ignored", 32'h0000_000F, 1'b0);
    apply(32'h0000_00F0, 3'd1, 1'b1, 6'd4, 6'd5, 1'b0);
    check("R10 reg", 32'h0000_0007, 1'b1);
    apply(32'h0000_00F0, 3'd1, 1'b1, 6'd0, 6'd5, 1'b0);
    check("R10 imm ignored", 32'h0000_0007, 1'b1);
  endtask

  task automatic t_reserved_r11;
    for (int k = 5; k < 8; k++) begin
      apply(32'hCAFE_F00D, 3'(k), 1'b0, 6'd3, 6'd7, 1'b1);
      check("R11", 32'hCAFE_F00D, 1'b1);
      apply(32'h0BAD_CAFE, 3'(k), 1'b1, 6'd3, 6'd7, 1'b0);
      check("R11", 32'h0BAD_CAFE, 1'b0);
    end
  endtask

  task automatic t_example_r12;
    apply(32'h0000_0005, 3'd0, 1'b0, 6'd1, 6'd0, 1'b0);
    check("R12 shift", 32'h0000_000A, 1'b0);
    checks++;
    if (result_o + operand_i !== 32'h0000_000F) begin
      errors++;
      $display("FAIL R12 sum: actual %h expected %h", result_o + operand_i, 32'h0000_000F);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_lsl_r1();
    t_lsr_r2();
    t_asr_r3();
    t_ror_r4();
    t_rrx_r5();
    t_zero_r6();
    t_full_r7();
    t_over_r8();
    t_asr_big_r9();
    t_src_r10();
    t_reserved_r11();
    t_example_r12();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule